// File: doc/BRIEF.md
# Shared-Pin I/O Port with Fixed Function Priority

This block manages an 8-pin I/O port whose pads are shared among three users: eight pulse-width channels, one serial-peripheral link, and plain software-controlled I/O. For every pad it chooses one owner in a fixed order. A pulse-width channel wins when it is enabled. The serial link wins next on its four pins. Otherwise the pad is a general-purpose pin driven from a data register and a direction register. The pulse-width and serial engines live outside the block. Their enables, output levels and direction requests arrive as plain inputs.

Every pad input passes through a two-flop synchronizer. The synchronized value goes out to the peripherals and also feeds two register views. The input view always shows the live pin state, whichever function owns the pin, so software can compare it with what is being driven and spot a short. The data view shows the stored bit for output pins and the synchronized pin level for input pins. The bus side is a simple select/write port with a combinational read mux.

Top module: `pin_mux_port`

## Requirements
- R1: After reset the data and direction registers hold 0. With no peripheral enabled, every pad output enable is 0 and the reads at offsets 0, 1 and 2 return 0, even while the pads are high.
- R2: A pin whose pulse-width enable bit is 1 drives pad_out from that channel's output, whatever the serial or general-purpose settings are. For pins 0 to 6 the pad output enable is 1.
- R3: Pin 7 with its pulse-width channel enabled has pad_oe[7]=0 while pwm_shutdown is 1, and pad_oe[7]=1 while pwm_shutdown is 0.
- R4: When spi_en is 1 and a pin's pulse-width enable is 0, pins 3..0 take pad_oe from spi_oe and pad_out from spi_out, bit for bit. The bit order is pin 0 = MISO, pin 1 = MOSI, pin 2 = clock, pin 3 = select. Pins 7..4 ignore spi_en.
- R5: A pin owned by neither peripheral has pad_oe equal to its direction bit and pad_out equal to its data bit.
- R6: A read at offset 0 returns, for each bit, the stored data bit if the direction bit is 1, and the synchronized pin level otherwise.
- R7: A read at offset 1 returns the synchronized pin levels, including on pins that a peripheral is driving. A write to offset 1 changes no register.
- R8: A change on pad_in becomes visible at offset 1 after exactly two rising clock edges. The same delay applies to the first edges after reset release.
- R9: Offset 2 is the direction register. It can be written and read back. Offset 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, used with bus_sel |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pwm_en | input | 8 | Per-pin pulse-width channel enable |
| pwm_out | input | 8 | Per-pin pulse-width output level |
| pwm_shutdown | input | 1 | Pin 7 channel in shutdown-input mode |
| spi_en | input | 1 | Serial link enabled |
| spi_out | input | 4 | Serial output levels, pins 3..0 |
| spi_oe | input | 4 | Serial per-pin drive requests, pins 3..0 |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pin_sync | output | 8 | Synchronized pad levels for the peripherals |

## Verification
The bench builds the port with its default width of eight pins. With that width the serial pins cover the lower half and the shutdown-capable channel is the top pin, so one build reaches every owner combination: pulse-width over serial, serial over general-purpose, and pins where the serial enable must have no effect. The two-stage synchronizer depth is fixed, which lets the bench count the exact edge at which a pad change reaches the input view. It also checks, in the data view, the mix of stored bits and pin levels that the direction register selects.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int unsigned SPI_PINS   = 4;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 2'd0,
        REG_INPUT = 2'd1,
        REG_DIR   = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_SPI  = 2'd1,
        OWN_PWM  = 2'd2
    } owner_e;
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stg;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.stg[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stg[DEPTH-1];
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pin_lvl,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  data_o,
    output logic [WIDTH-1:0]  dir_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel_e'(addr))
                REG_DATA: st_d.data = wdata;
                REG_DIR:  st_d.dir  = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel_e'(addr))
            REG_DATA:  rdata = (st_q.dir & st_q.data) | (~st_q.dir & pin_lvl);
            REG_INPUT: rdata = pin_lvl;
            REG_DIR:   rdata = st_q.dir;
            default:   rdata = '0;
        endcase
    end

    assign data_o = st_q.data;
    assign dir_o  = st_q.dir;
endmodule

// File: rtl/pinmux_pin_sel.sv
module pinmux_pin_sel
    import pinmux_pkg::*;
#(
    parameter bit HAS_SPI      = 1'b0,
    parameter bit CAN_SHUTDOWN = 1'b0
) (
    input  logic pwm_en,
    input  logic pwm_lvl,
    input  logic shutdown,
    input  logic spi_en,
    input  logic spi_lvl,
    input  logic spi_drv,
    input  logic gpio_dir,
    input  logic gpio_lvl,
    output logic oe,
    output logic lvl
);
    owner_e owner;

    always_comb begin
        if (pwm_en)                  owner = OWN_PWM;
        else if (HAS_SPI && spi_en)  owner = OWN_SPI;
        else                         owner = OWN_GPIO;
    end

    always_comb begin
        case (owner)
            OWN_PWM: begin
                oe  = !(CAN_SHUTDOWN && shutdown);
                lvl = pwm_lvl;
            end
            OWN_SPI: begin
                oe  = spi_drv;
                lvl = spi_lvl;
            end
            default: begin
                oe  = gpio_dir;
                lvl = gpio_lvl;
            end
        endcase
    end
endmodule

// File: rtl/pin_mux_port.sv
module pin_mux_port
    import pinmux_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pwm_en,
    input  logic [NUM_PINS-1:0] pwm_out,
    input  logic                pwm_shutdown,
    input  logic                spi_en,
    input  logic [SPI_PINS-1:0] spi_out,
    input  logic [SPI_PINS-1:0] spi_oe,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pin_sync
);
    localparam int unsigned TOP_PIN = NUM_PINS - 1;
    localparam int unsigned PAD_W   = NUM_PINS - SPI_PINS;

    logic [NUM_PINS-1:0] gpio_data;
    logic [NUM_PINS-1:0] gpio_dir;
    logic [NUM_PINS-1:0] spi_out_w;
    logic [NUM_PINS-1:0] spi_oe_w;

    assign spi_out_w = {{PAD_W{1'b0}}, spi_out};
    assign spi_oe_w  = {{PAD_W{1'b0}}, spi_oe};

    pinmux_sync #(
        .WIDTH (NUM_PINS),
        .DEPTH (SYNC_DEPTH)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_sync)
    );

    pinmux_regs #(
        .WIDTH (NUM_PINS)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_sel && bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pin_lvl (pin_sync),
        .rdata   (bus_rdata),
        .data_o  (gpio_data),
        .dir_o   (gpio_dir)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pinmux_pin_sel #(
            .HAS_SPI      (p < SPI_PINS),
            .CAN_SHUTDOWN (p == TOP_PIN)
        ) i_sel (
            .pwm_en   (pwm_en[p]),
            .pwm_lvl  (pwm_out[p]),
            .shutdown (pwm_shutdown),
            .spi_en   (spi_en),
            .spi_lvl  (spi_out_w[p]),
            .spi_drv  (spi_oe_w[p]),
            .gpio_dir (gpio_dir[p]),
            .gpio_lvl (gpio_data[p]),
            .oe       (pad_oe[p]),
            .lvl      (pad_out[p])
        );
    end
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk
    import pinmux_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] pwm_en,
    input logic [NUM_PINS-1:0] pwm_out,
    input logic                pwm_shutdown,
    input logic                spi_en,
    input logic [SPI_PINS-1:0] spi_out,
    input logic [SPI_PINS-1:0] spi_oe,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out
);
    localparam logic [NUM_PINS-1:0] LOW_MASK = {1'b0, {(NUM_PINS-1){1'b1}}};

    logic [1:0]          up_cnt;
    logic [SPI_PINS-1:0] spi_own;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    always_comb spi_own = spi_en ? ~pwm_en[SPI_PINS-1:0] : '0;

    // R2
    pwm_owns_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pwm_en & LOW_MASK) == (pwm_en & LOW_MASK)) &&
        ((pad_out & pwm_en) == (pwm_out & pwm_en)));

    // R3
    top_shutdown_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en[NUM_PINS-1] && pwm_shutdown) |-> !pad_oe[NUM_PINS-1]);

    // R4
    spi_follows_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe[SPI_PINS-1:0] & spi_own) == (spi_oe & spi_own)) &&
        ((pad_out[SPI_PINS-1:0] & spi_own) == (spi_out & spi_own)));

    // R7
    input_view_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2 && bus_addr == REG_INPUT) |-> bus_rdata == $past(pad_in, 2));

    // R9
    dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_DIR) |=>
        (bus_addr != REG_DIR || bus_rdata == $past(bus_wdata)));
endmodule

bind pin_mux_port pinmux_port_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pwm_en       (pwm_en),
    .pwm_out      (pwm_out),
    .pwm_shutdown (pwm_shutdown),
    .spi_en       (spi_en),
    .spi_out      (spi_out),
    .spi_oe       (spi_oe),
    .pad_in       (pad_in),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out)
);

// File: tb/test_pin_mux_port.sv
module test_pin_mux_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pwm_en = '0;
    logic [7:0] pwm_out = '0;
    logic       pwm_shutdown = 1'b0;
    logic       spi_en = 1'b0;
    logic [3:0] spi_out = '0;
    logic [3:0] spi_oe = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] pin_sync;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_mux_port i_pin_mux_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_en(pwm_en), .pwm_out(pwm_out), .pwm_shutdown(pwm_shutdown),
        .spi_en(spi_en), .spi_out(spi_out), .spi_oe(spi_oe),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pin_sync(pin_sync)
    );

    // fields: pwm_en, pwm_out, shutdown, spi_en, spi_out, spi_oe, dir, data, exp_oe, exp_out
    localparam int NVEC = 7;
    localparam logic [57:0] VEC [NVEC] = '{
        {8'h00, 8'hFF, 1'b0, 1'b0, 4'hF, 4'hF, 8'hF0, 8'hA5, 8'hF0, 8'hA5},
        {8'hFF, 8'h3C, 1'b0, 1'b1, 4'h0, 4'hF, 8'h00, 8'hFF, 8'hFF, 8'h3C},
        {8'hFF, 8'h3C, 1'b1, 1'b1, 4'h0, 4'hF, 8'h00, 8'hFF, 8'h7F, 8'h3C},
        {8'h00, 8'h00, 1'b0, 1'b1, 4'hA, 4'h6, 8'hFF, 8'h50, 8'hF6, 8'h5A},
        {8'h05, 8'hFF, 1'b1, 1'b1, 4'h0, 4'hF, 8'h00, 8'h00, 8'h0F, 8'h05},
        {8'h80, 8'h00, 1'b0, 1'b0, 4'hF, 4'hF, 8'h0F, 8'hFF, 8'h8F, 8'h7F},
        {8'h80, 8'h80, 1'b1, 1'b0, 4'h0, 4'h0, 8'hFF, 8'h00, 8'h7F, 8'h80}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        // R1: reset state while pads sit high
        pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        bus_addr = 2'd0; #1 check("R1 data view in reset", bus_rdata, 8'h00);
        bus_addr = 2'd1; #1 check("R1 input view in reset", bus_rdata, 8'h00);
        bus_addr = 2'd2; #1 check("R1 dir in reset", bus_rdata, 8'h00);
        check("R1 pad_oe in reset", pad_oe, 8'h00);

        // R8: two-edge latency from reset release, then for a change
        @(negedge clk);
        bus_addr = 2'd1;
        rst_n = 1'b1;
        @(negedge clk); check("R8 one edge after release", bus_rdata, 8'h00);
        @(negedge clk); check("R8 two edges after release", bus_rdata, 8'hFF);
        pad_in = 8'h3C;
        @(negedge clk); check("R8 one edge after change", bus_rdata, 8'hFF);
        @(negedge clk); check("R8 two edges after change", bus_rdata, 8'h3C);

        // R2/R3/R4/R5 table walk
        for (int v = 0; v < NVEC; v++) begin
            bus_write(2'd2, VEC[v][31:24]);
            bus_write(2'd0, VEC[v][23:16]);
            pwm_en       = VEC[v][57:50];
            pwm_out      = VEC[v][49:42];
            pwm_shutdown = VEC[v][41];
            spi_en       = VEC[v][40];
            spi_out      = VEC[v][39:36];
            spi_oe       = VEC[v][35:32];
            #1;
            check($sformatf("R2/R3/R4/R5 vec%0d pad_oe", v), pad_oe, VEC[v][15:8]);
            check($sformatf("R2/R3/R4/R5 vec%0d pad_out", v), pad_out, VEC[v][7:0]);
        end
        pwm_en = '0; pwm_shutdown = 1'b0; spi_en = 1'b0;

        // R6: data view mixes stored bits and pin levels
        bus_write(2'd2, 8'h0F);
        bus_write(2'd0, 8'hA5);
        bus_read(2'd0, rd); check("R6 mixed direction read", rd, 8'h35);
        bus_write(2'd2, 8'h00);
        bus_read(2'd0, rd); check("R6 all-input read", rd, 8'h3C);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd0, rd); check("R6 all-output read", rd, 8'hA5);

        // R7: input view is read-only and shows driven pins too
        bus_write(2'd1, 8'hAA);
        bus_read(2'd1, rd); check("R7 write to input view ignored", rd, 8'h3C);
        bus_read(2'd0, rd); check("R7 data untouched by input write", rd, 8'hA5);
        bus_read(2'd2, rd); check("R7 dir untouched by input write", rd, 8'hFF);
        pwm_en = 8'h01; pwm_out = 8'h01;
        bus_read(2'd1, rd); check("R7 input view on driven pin", rd, 8'h3C);
        pwm_en = '0;

        // R9 and R5: direction read-back and general-purpose drive
        bus_write(2'd2, 8'h5A);
        bus_read(2'd2, rd); check("R9 dir read-back", rd, 8'h5A);
        bus_read(2'd3, rd); check("R9 unused offset reads zero", rd, 8'h00);
        check("R5 pad_oe from dir", pad_oe, 8'h5A);
        check("R5 pad_out from data", pad_out, 8'hA5);

        // R4: serial enable leaves upper pins alone
        spi_en = 1'b1; spi_oe = 4'h0; spi_out = 4'hF;
        #1;
        check("R4 upper pins ignore spi_en", pad_oe, 8'h50);
        check("R4 lower pins follow serial", pad_out, 8'hAF);
        spi_en = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule